// File: doc/BRIEF.md
# Paged Memory Mapper with Cartridge Banking

This block sits between a 16-bit byte-addressed CPU and a 256-page physical memory space made of 8 KB pages. For every access it splits the address into a 3-bit CPU page and a 13-bit in-page offset. It turns the CPU page into an 8-bit physical page and classifies that page into a target region. The regions are boot ROM, SRAM, expansion space, speech space and DRAM. Translation is purely combinational, so the memory side sees the physical page in the same cycle as the CPU address.

Eight page registers hold the translation for the normal case. A small register window makes them readable and writable. The window sits high in the address space in native mode and low in compatibility mode. Eleven mode flags are loaded one bit at a time through a single-bit I/O port. They select the mode:
- A forced map mode bypasses the registers and offsets the page by a fixed base.
- Native mode uses the registers for every page.
- Compatibility mode replaces CPU page 3 with a two-bank cartridge image. That image is either bank-switched by writes or writable, with separate write-enable flags for its lower and upper 4 KB.

Top module: `paged_mem_mapper`

## Requirements
- R1: `page_off` always equals address bits 12:0; the CPU page is address bits 15:13.
- R2: While the map flag (flag 6) is 1, outside the register window, `phys_page` equals 0xF0 plus the CPU page, whatever the page registers hold.
- R3: With the map flag 0 and the native flag (flag 5) 1, `phys_page` equals the page register indexed by the CPU page.
- R4: With the map and native flags both 0, pages other than 3 use the page registers. A read of page 3 gives physical page 0x36 when the cartridge-paging flag (flag 7) is 1 or the bank bit is 0, and 0x37 otherwise.
- R5: In compatibility mode with the cartridge-paging flag 0, a write to page 3 has `mem_wr` low, reports physical page 0x36, and loads the bank bit from address bit 1 at the clock edge.
- R6: In compatibility mode with the cartridge-paging flag 1, a write to page 3 targets page 0x36. In the lower half (address bit 12 = 0), `mem_wr` is asserted only when flag 8 is 1. In the upper half, `mem_wr` is asserted only when flag 9 is 1.
- R7: `region` encodes the target as follows: 0 DRAM (any other page), 1 boot ROM (pages 0xF0–0xF1), 2 SRAM (0xE8–0xEF), 3 expansion space (0xBA), 4 speech space (0xBC), 5 register window. A write to boot ROM never asserts `mem_wr`.
- R8: The page registers are decoded at 0xF110–0xF117 when the native flag is 1 and at 0x8000–0x8007 when it is 0. Address bits 2:0 select the register. In the window, `reg_hit` is 1 and `reg_rdata` returns the selected register, which a write updates at the clock edge. Outside the window, `reg_rdata` is 0.
- R9: The register window takes priority over translation: an access inside it never asserts `mem_rd` or `mem_wr`, and `region` reads 5.
- R10: An I/O write to address 0x775+k (k = 0..10) loads flag k from `io_bit` at the clock edge. Accesses in that same cycle still use the old flags.
- R11: After reset, only the map flag is set, and all page registers and the bank bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | Read access |
| cpu_wr | input | 1 | Write access |
| cpu_wdata | input | 8 | Write data (used by the register window) |
| io_wr | input | 1 | Single-bit I/O write strobe |
| io_addr | input | 12 | Single-bit I/O address |
| io_bit | input | 1 | Single-bit I/O data |
| phys_page | output | 8 | Translated physical page |
| page_off | output | 13 | Offset within the page |
| region | output | 3 | Target region code |
| mem_rd | output | 1 | Read reaches memory |
| mem_wr | output | 1 | Write reaches memory |
| reg_hit | output | 1 | Address falls in the page-register window |
| reg_rdata | output | 8 | Page register read data |

## Verification
A flag update over the I/O port and a CPU access can occur in the same cycle. For example, the map flag can be set while a page-3 read is under way, or cleared while a page-register-backed access is under way. The bench drives both strobes in one cycle. It expects the translation of that cycle to follow the old flags and the next access to follow the new ones. A second overlap is a bank-switching write followed directly by a page-3 read. Here the read must already see the bank bit taken from the write's address bit 1.

// File: rtl/paged_mem_mapper.sv
module paged_mem_mapper #(
  parameter int AW = 16,
  parameter int OW = 13,
  parameter int PW = 8,
  parameter int DW = 8,
  parameter int IOW = 12,
  parameter int NFLAG = 11,
  parameter logic [IOW-1:0] FLAG_BASE = 12'h775,
  parameter logic [PW-1:0] MAP_BASE = 8'hF0,
  parameter logic [PW-1:0] CART_PAGE = 8'h36,
  parameter logic [AW-1:0] NATIVE_WIN = 16'hF110,
  parameter logic [AW-1:0] COMPAT_WIN = 16'h8000,
  parameter int CART_SLOT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          io_wr,
  input  logic [IOW-1:0] io_addr,
  input  logic          io_bit,
  output logic [PW-1:0] phys_page,
  output logic [OW-1:0] page_off,
  output logic [2:0]    region,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          reg_hit,
  output logic [DW-1:0] reg_rdata
);
  localparam int SW = AW - OW;
  localparam int NREG = 1 << SW;
  localparam int F_NATIVE = 5;
  localparam int F_MAP = 6;
  localparam int F_CART = 7;
  localparam int F_WLO = 8;
  localparam int F_WHI = 9;
  localparam logic [NFLAG-1:0] RST_FLAGS = NFLAG'(1) << F_MAP;
  localparam logic [2:0] RG_DRAM = 3'd0, RG_ROM = 3'd1, RG_SRAM = 3'd2,
                         RG_DSR = 3'd3, RG_SPEECH = 3'd4, RG_WIN = 3'd5;
  localparam logic [PW-1:0] ROM_LO = 8'hF0, ROM_HI = 8'hF1;
  localparam logic [PW-1:0] SRAM_LO = 8'hE8, SRAM_HI = 8'hEF;
  localparam logic [PW-1:0] DSR_PG = 8'hBA, SPEECH_PG = 8'hBC;

  logic [NFLAG-1:0] flags;
  logic [DW-1:0]    page_reg [NREG];
  logic             bank;

  logic [SW-1:0]  cpu_pg;
  logic [AW-1:0]  win_base;
  logic [SW-1:0]  reg_idx;
  logic           cart_slot, bank_sel, wr_ok, io_in_rng;
  logic [IOW-1:0] io_idx;
  logic [2:0]     pg_class;

  assign cpu_pg   = cpu_addr[AW-1:OW];
  assign page_off = cpu_addr[OW-1:0];
  assign reg_idx  = cpu_addr[SW-1:0];
  assign win_base = flags[F_NATIVE] ? NATIVE_WIN : COMPAT_WIN;
  assign reg_hit  = cpu_addr[AW-1:SW] == win_base[AW-1:SW];
  assign reg_rdata = reg_hit ? page_reg[reg_idx] : '0;

  assign cart_slot = !flags[F_MAP] && !flags[F_NATIVE] && (cpu_pg == SW'(CART_SLOT));
  assign bank_sel  = cart_slot && !flags[F_CART] && cpu_wr && !reg_hit;
  assign wr_ok     = !cart_slot ||
                     (flags[F_CART] && (cpu_addr[OW-1] ? flags[F_WHI] : flags[F_WLO]));

  always_comb begin
    if (flags[F_MAP])
      phys_page = MAP_BASE + PW'(cpu_pg);
    else if (!cart_slot)
      phys_page = page_reg[cpu_pg];
    else if (cpu_wr || flags[F_CART] || !bank)
      phys_page = CART_PAGE;
    else
      phys_page = CART_PAGE + PW'(1);
  end

  always_comb begin
    if (phys_page >= ROM_LO && phys_page <= ROM_HI)        pg_class = RG_ROM;
    else if (phys_page >= SRAM_LO && phys_page <= SRAM_HI) pg_class = RG_SRAM;
    else if (phys_page == DSR_PG)                          pg_class = RG_DSR;
    else if (phys_page == SPEECH_PG)                       pg_class = RG_SPEECH;
    else                                                   pg_class = RG_DRAM;
  end

  assign region = reg_hit ? RG_WIN : pg_class;
  assign mem_rd = cpu_rd && !reg_hit;
  assign mem_wr = cpu_wr && !reg_hit && (pg_class != RG_ROM) && wr_ok;

  assign io_idx    = io_addr - FLAG_BASE;
  assign io_in_rng = (io_addr >= FLAG_BASE) && (io_addr < FLAG_BASE + IOW'(NFLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= RST_FLAGS;
      bank  <= 1'b0;
      for (int k = 0; k < NREG; k++) page_reg[k] <= '0;
    end else begin
      if (io_wr && io_in_rng)
        for (int k = 0; k < NFLAG; k++)
          if (io_idx == IOW'(k)) flags[k] <= io_bit;
      if (cpu_wr && reg_hit) page_reg[reg_idx] <= cpu_wdata;
      if (bank_sel) bank <= cpu_addr[1];
    end
  end

  p_rom_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_ROM) |-> !mem_wr);

  p_window_nomem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |-> (!mem_rd && !mem_wr));

  p_bank_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel |=> (bank == $past(cpu_addr[1])));

  p_reg_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && reg_hit) |=> (page_reg[$past(reg_idx)] == $past(cpu_wdata)));

  p_cart_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_slot && flags[F_CART] && cpu_wr && !reg_hit &&
     !(cpu_addr[OW-1] ? flags[F_WHI] : flags[F_WLO])) |-> !mem_wr);

  p_flag_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_in_rng && io_idx == IOW'(F_MAP)) |=> (flags[F_MAP] == $past(io_bit)));
endmodule

// File: tb/paged_mem_mapper_tb.sv
module paged_mem_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        io_wr = 1'b0;
  logic [11:0] io_addr = '0;
  logic        io_bit = 1'b0;
  logic [7:0]  phys_page;
  logic [12:0] page_off;
  logic [2:0]  region;
  logic        mem_rd, mem_wr, reg_hit;
  logic [7:0]  reg_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [10:0] m_flags;
  logic [7:0]  m_reg [8];
  logic        m_bank;

  always #4 clk = ~clk;

  paged_mem_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .io_wr(io_wr), .io_addr(io_addr), .io_bit(io_bit),
    .phys_page(phys_page), .page_off(page_off), .region(region), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .reg_hit(reg_hit), .reg_rdata(reg_rdata));

  function automatic logic [2:0] classify(input logic [7:0] p);
    if (p == 8'hF0 || p == 8'hF1) return 3'd1;
    if (p >= 8'hE8 && p <= 8'hEF) return 3'd2;
    if (p == 8'hBA) return 3'd3;
    if (p == 8'hBC) return 3'd4;
    return 3'd0;
  endfunction

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [7:0] wd, input logic iow, input logic [11:0] ioa,
                        input logic iob);
    logic nat, mp, cp, hit, slot, ok;
    logic [2:0] pg, rg;
    logic [7:0] ph, rdv;
    logic exp_rd, exp_wr;
    string tag;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    io_wr = iow; io_addr = ioa; io_bit = iob;
    #2;
    nat = m_flags[5]; mp = m_flags[6]; cp = m_flags[7];
    pg = a[15:13];
    hit = nat ? (a[15:3] == 13'h1E22) : (a[15:3] == 13'h1000);
    slot = !mp && !nat && pg == 3'd3;
    ok = 1'b1;
    if (mp) begin ph = 8'hF0 + 8'(pg); tag = "R2"; end
    else if (!slot) begin ph = m_reg[pg]; tag = nat ? "R3" : "R4"; end
    else if (wr) begin
      ph = 8'h36;
      if (!cp) begin ok = 1'b0; tag = "R5"; end
      else begin ok = a[12] ? m_flags[9] : m_flags[8]; tag = "R6"; end
    end else begin ph = (cp || !m_bank) ? 8'h36 : 8'h37; tag = "R4"; end
    rg = classify(ph);
    if (rg == 3'd1 && wr) tag = "R7";
    exp_wr = wr && !hit && rg != 3'd1 && ok;
    exp_rd = rd && !hit;
    rdv = hit ? m_reg[a[2:0]] : 8'h00;
    if (hit) begin rg = 3'd5; ph = phys_page; tag = "R8/R9"; end
    n_chk++;
    if ({phys_page, page_off, region, mem_rd, mem_wr, reg_hit, reg_rdata} !==
        {ph, a[12:0], rg, exp_rd, exp_wr, hit, rdv}) begin
      n_bad++;
      $display("FAIL %s (R1 offset) addr=%h rd=%b wr=%b: got page=%h off=%h rg=%0d mrd=%b mwr=%b hit=%b rdat=%h exp page=%h off=%h rg=%0d mrd=%b mwr=%b hit=%b rdat=%h",
        tag, a, rd, wr, phys_page, page_off, region, mem_rd, mem_wr, reg_hit, reg_rdata,
        ph, a[12:0], rg, exp_rd, exp_wr, hit, rdv);
    end
    @(posedge clk); #1;
    if (wr && hit) m_reg[a[2:0]] = wd;
    if (wr && !hit && slot && !cp) m_bank = a[1];
    if (iow && ioa >= 12'h775 && ioa < 12'h780) m_flags[ioa - 12'h775] = iob;
    cpu_rd = 0; cpu_wr = 0; io_wr = 0;
  endtask

  task automatic set_flag(input int k, input logic v);
    access(16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 12'h775 + 12'(k), v);
  endtask

  task automatic load_regs(input logic [15:0] base, input logic [7:0] x);
    logic [7:0] vals [8];
    vals = '{8'hE8, 8'hF1, 8'hBA, 8'hBC, 8'h36, 8'h12, 8'hEF, 8'hF0};
    for (int i = 0; i < 8; i++) access(base + 16'(i), 0, 1, vals[i] ^ x, 0, 0, 0);
    for (int i = 0; i < 8; i++) access(base + 16'(i), 1, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic sweep();
    logic [15:0] offs [6];
    offs = '{16'h0000, 16'h0002, 16'h0FFE, 16'h1000, 16'h1110, 16'h1FFF};
    for (int p = 0; p < 8; p++)
      for (int o = 0; o < 6; o++) begin
        access(16'(p << 13) + offs[o], 0, 1, 8'(p * 29 + o) ^ 8'h5A, 0, 0, 0);
        access(16'(p << 13) + offs[o], 1, 0, 8'h00, 0, 0, 0);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_flags = 11'h040; m_bank = 0;
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: reset state - map mode, registers zero (read via compat window)
    for (int i = 0; i < 8; i++) access(16'h8000 + 16'(i), 1, 0, 0, 0, 0, 0);
    // R2: map mode sweep, with register window priority (R9) at 0x8000
    sweep();
    load_regs(16'h8000, 8'h00);
    sweep();
    // R3/R8: native mode, window moves to 0xF110
    set_flag(6, 0); set_flag(5, 1);
    load_regs(16'hF110, 8'h01);
    sweep();
    // R4/R5: compatibility mode, bank switching
    set_flag(5, 0);
    load_regs(16'h8000, 8'h00);
    sweep();
    access(16'h6002, 0, 1, 0, 0, 0, 0);
    access(16'h6100, 1, 0, 0, 0, 0, 0);
    access(16'h7FF0, 0, 1, 0, 0, 0, 0);
    access(16'h6100, 1, 0, 0, 0, 0, 0);
    // R6: cartridge paging with every write-enable combination
    access(16'h6002, 0, 1, 0, 0, 0, 0);
    set_flag(7, 1);
    for (int c = 0; c < 4; c++) begin
      set_flag(8, c[0]); set_flag(9, c[1]);
      for (int o = 0; o < 4; o++) begin
        access(16'h6000 + 16'(o * 16'h0800), 0, 1, 0, 0, 0, 0);
        access(16'h6000 + 16'(o * 16'h0800), 1, 0, 0, 0, 0, 0);
      end
    end
    sweep();
    // R10: flag write in the same cycle as an access uses old flags
    set_flag(7, 0);
    access(16'h6002, 0, 1, 0, 0, 0, 0);
    access(16'h6000, 1, 0, 0, 1, 12'h77B, 1);
    access(16'h6000, 1, 0, 0, 0, 0, 0);
    access(16'h2000, 1, 0, 0, 1, 12'h77B, 0);
    access(16'h2000, 1, 0, 0, 0, 0, 0);
    access(16'h6000, 1, 0, 0, 1, 12'h77A, 1);
    access(16'hF110, 1, 0, 0, 0, 0, 0);
    access(16'h8000, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule